// File: doc/BRIEF.md
# Multicycled MAC-Array FIR Filter

This block is a programmable finite impulse response filter built around sixteen multiply-accumulate lanes. Each lane is reused over several system clocks, so one set of sixteen multipliers can serve 16, 32, 64 or 128 taps. The price of a longer filter is a lower sample rate. Samples and coefficients arrive as 16-bit two's complement words. Each stored coefficient is cut to 12 bits, and products are summed in 32-bit wrapping arithmetic.

A 32-bit cascade word from an upstream filter is added to the local sum at full width. Filters can therefore be chained without scaling. The lanes can also be split into two independent half-length filters, each with its own sample input, cascade input and result. A decimate-by-two option computes a result on every second accepted sample. At a given input rate this allows twice the taps.

Coefficients are written through a simple write port and survive reset. The operating mode is latched only while the synchronous reset is asserted.

Top module: `fir_mac`

## Requirements
- R1: With tap code `modeTaps` = k and single mode, the filter has N = 16·2^k taps, and the result for sample n is cascadeA + Σ_{t=0}^{N-1} c[t]·x[n−t]. Here c[t] is the narrowed coefficient stored at address t, and samples before the last reset count as zero.
- R2: Without decimation, with M = 2^k, a sample may be accepted every M clocks. `resultValid` and the result for that sample appear right after the M-th rising edge following the edge that accepted it.
- R3: A coefficient is narrowed to bits [15:4] of the written word, kept as a signed 12-bit value (arithmetic truncation). The lower four bits have no effect.
- R4: All accumulation, including the cascade addition, wraps modulo 2^32 without saturation.
- R5: The cascade inputs are added at full 32-bit width, unscaled. They are sampled at the edge that registers the result.
- R6: With `modeDual` = 1, channel A computes cascadeA + Σ_{t<N/2} c[t]·xA[n−t] and channel B computes cascadeB + Σ_{t<N/2} c[N/2+t]·xB[n−t], with the same timing as R2. In single mode `resultB` stays zero.
- R7: With `modeDecim` = 1, a sample may be accepted every max(M/2,1) clocks. Counting from reset, a result is produced after the 2nd, 4th, 6th… accepted sample, over the newest N samples. It appears right after the M-th rising edge following that sample's edge.
- R8: The mode inputs are latched only while `rst` is high. Changing them at any other time has no effect on the results.
- R9: Synchronous reset clears the delay line, the accumulators, `resultA`, `resultB` and `resultValid`.
- R10: `resultValid` is high for one clock per result, and `resultA`/`resultB` hold their value in every clock in which `resultValid` is low.
- R11: When `coefWrEn` is high at a rising edge, `coefData` is stored at `coefAddr` (0–127). Reset does not alter the coefficient store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; latches the mode |
| modeTaps | input | 2 | Tap code k, N = 16·2^k |
| modeDual | input | 1 | Two half-length filters when high |
| modeDecim | input | 1 | Decimate-by-two when high |
| coefWrEn | input | 1 | Coefficient write strobe |
| coefAddr | input | 7 | Coefficient address |
| coefData | input | 16 | Coefficient word, two's complement |
| sampleValid | input | 1 | Sample strobe for both channels |
| sampleA | input | 16 | Channel A sample |
| sampleB | input | 16 | Channel B sample (dual mode) |
| cascadeA | input | 32 | Upstream partial sum, channel A |
| cascadeB | input | 32 | Upstream partial sum, channel B |
| resultValid | output | 1 | One-clock result strobe |
| resultA | output | 32 | Channel A result |
| resultB | output | 32 | Channel B result (zero in single mode) |

## Verification
A result is due M rising edges after the edge that accepts the sample it belongs to. With decimation this holds only for every second sample. For every accepted sample, the bench computes the edge index at which the result falls due and stores the expected values under that index. It then compares the outputs at each falling edge against the entry for the edge just passed. As a result, both a late or early `resultValid` and a wrong value are reported, and every cycle without a due result must show `resultValid` low.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int LANES     = 16;
  localparam int SAMPLE_W  = 16;
  localparam int COEF_IN_W = 16;
  localparam int COEF_W    = 12;
  localparam int ACC_W     = 32;
  localparam int MAX_MULT  = 8;
  localparam int CODE_W    = $clog2($clog2(MAX_MULT) + 1);
  localparam int PHASE_W   = (MAX_MULT > 1) ? $clog2(MAX_MULT) : 1;
  localparam int MAX_TAPS  = LANES * MAX_MULT;
  localparam int ADDR_W    = $clog2(MAX_TAPS);

  typedef struct packed {
    logic [CODE_W-1:0] tapsCode;
    logic              dual;
    logic              decim;
  } fir_mode_t;

  typedef struct packed {
    logic               shift;
    logic               active;
    logic               first;
    logic               last;
    logic               skew;
    logic [PHASE_W-1:0] phase;
  } fir_ctrl_t;
endpackage

// File: rtl/fir_mac_ctrl.sv
module fir_mac_ctrl
  import fir_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleValid,
  input  fir_mode_t modeQ,
  output fir_ctrl_t ctrl
);
  logic busy, pairToggle, skew, start, atLast;
  logic [PHASE_W-1:0] phase, lastPhase;
  logic unusedDual;

  assign unusedDual = modeQ.dual;

  always_comb begin
    lastPhase = PHASE_W'((1 << modeQ.tapsCode) - 1);
    start     = sampleValid && (!modeQ.decim || pairToggle);
    atLast    = (phase == lastPhase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      phase      <= '0;
      pairToggle <= 1'b0;
      skew       <= 1'b0;
    end else begin
      busy <= start || (busy && !atLast);
      if (start) phase <= '0;
      else if (busy) phase <= phase + 1'b1;
      pairToggle <= modeQ.decim && (sampleValid ? !pairToggle : pairToggle);
      if (start) skew <= 1'b0;
      else if (sampleValid && busy) skew <= 1'b1;
    end
  end

  always_comb begin
    ctrl.shift  = sampleValid;
    ctrl.active = busy;
    ctrl.first  = (phase == '0);
    ctrl.last   = atLast;
    ctrl.skew   = skew;
    ctrl.phase  = phase;
  end
endmodule

// File: rtl/fir_mac_datapath.sv
module fir_mac_datapath
  import fir_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  fir_ctrl_t           ctrl,
  input  fir_mode_t           modeQ,
  input  logic                coefWrEn,
  input  logic [ADDR_W-1:0]   coefAddr,
  input  logic [COEF_IN_W-1:0] coefData,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic [ACC_W-1:0]    cascadeA,
  input  logic [ACC_W-1:0]    cascadeB,
  output logic                resultValid,
  output logic [ACC_W-1:0]    resultA,
  output logic [ACC_W-1:0]    resultB
);
  localparam int LINE_D = MAX_TAPS + 1;
  localparam int IDX_W  = $clog2(LINE_D);
  localparam int HALF   = LANES / 2;
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int DROP_W = COEF_IN_W - COEF_W;

  logic signed [COEF_W-1:0]   coefMem [MAX_TAPS];
  logic signed [SAMPLE_W-1:0] lineA [LINE_D];
  logic signed [SAMPLE_W-1:0] lineB [LINE_D];
  logic [ACC_W-1:0]           partials [LANES];
  logic [ADDR_W:0]            halfTaps;
  logic [ACC_W-1:0]           sumLo, sumHi;
  logic [DROP_W-1:0]          unusedLowBits;
  logic                       unusedDecim;

  assign unusedLowBits = coefData[DROP_W-1:0];
  assign unusedDecim   = modeQ.decim;
  assign halfTaps      = (ADDR_W+1)'((LANES << modeQ.tapsCode) >> 1);

  // coefficient store keeps only the narrowed upper bits
  always_ff @(posedge clk) begin
    if (coefWrEn) coefMem[coefAddr] <= coefData[COEF_IN_W-1 -: COEF_W];
  end

  // delay lines, index 0 holds the newest sample
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINE_D; i++) begin
        lineA[i] <= '0;
        lineB[i] <= '0;
      end
    end else if (ctrl.shift) begin
      lineA[0] <= sampleA;
      lineB[0] <= sampleB;
      for (int i = 1; i < LINE_D; i++) begin
        lineA[i] <= lineA[i-1];
        lineB[i] <= lineB[i-1];
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LOCAL_LANE = k % HALF;
    localparam bit UPPER      = (k >= HALF);
    logic [IDX_W-1:0]          laneIdx, tapIdx, readIdx;
    logic [ADDR_W-1:0]         coefIdx;
    logic                      useB;
    logic signed [SAMPLE_W-1:0] x;
    logic signed [COEF_W-1:0]  c;
    logic signed [PROD_W-1:0]  prodNarrow;
    logic [ACC_W-1:0]          prodWide, acc, partial;

    always_comb begin
      laneIdx    = modeQ.dual ? IDX_W'(LOCAL_LANE) : IDX_W'(k);
      tapIdx     = IDX_W'(laneIdx << modeQ.tapsCode) + IDX_W'(ctrl.phase);
      readIdx    = tapIdx + IDX_W'(ctrl.skew);
      useB       = modeQ.dual && UPPER;
      x          = useB ? lineB[readIdx] : lineA[readIdx];
      coefIdx    = useB ? ADDR_W'(halfTaps + (ADDR_W+1)'(tapIdx)) : ADDR_W'(tapIdx);
      c          = coefMem[coefIdx];
      prodNarrow = x * c;
      prodWide   = {{(ACC_W-PROD_W){prodNarrow[PROD_W-1]}}, prodNarrow};
      partial    = ctrl.first ? prodWide : acc + prodWide;
    end

    always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else if (ctrl.active) acc <= partial;
    end

    assign partials[k] = partial;
  end

  always_comb begin
    sumLo = '0;
    sumHi = '0;
    for (int i = 0; i < HALF; i++) sumLo = sumLo + partials[i];
    for (int i = HALF; i < LANES; i++) sumHi = sumHi + partials[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      resultA     <= '0;
      resultB     <= '0;
    end else begin
      resultValid <= ctrl.active && ctrl.last;
      if (ctrl.active && ctrl.last) begin
        resultA <= cascadeA + (modeQ.dual ? sumLo : sumLo + sumHi);
        resultB <= modeQ.dual ? cascadeB + sumHi : '0;
      end
    end
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import fir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CODE_W-1:0]    modeTaps,
  input  logic                 modeDual,
  input  logic                 modeDecim,
  input  logic                 coefWrEn,
  input  logic [ADDR_W-1:0]    coefAddr,
  input  logic [COEF_IN_W-1:0] coefData,
  input  logic                 sampleValid,
  input  logic [SAMPLE_W-1:0]  sampleA,
  input  logic [SAMPLE_W-1:0]  sampleB,
  input  logic [ACC_W-1:0]     cascadeA,
  input  logic [ACC_W-1:0]     cascadeB,
  output logic                 resultValid,
  output logic [ACC_W-1:0]     resultA,
  output logic [ACC_W-1:0]     resultB
);
  fir_mode_t modeQ;
  fir_ctrl_t ctrl;

  // mode is only taken while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ.tapsCode <= modeTaps;
      modeQ.dual     <= modeDual;
      modeQ.decim    <= modeDecim;
    end
  end

  fir_mac_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .modeQ(modeQ), .ctrl(ctrl)
  );

  fir_mac_datapath u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .modeQ(modeQ),
    .coefWrEn(coefWrEn), .coefAddr(coefAddr), .coefData(coefData),
    .sampleA(sampleA), .sampleB(sampleB),
    .cascadeA(cascadeA), .cascadeB(cascadeB),
    .resultValid(resultValid), .resultA(resultA), .resultB(resultB)
  );
endmodule

// File: rtl/fir_mac_checks.sv
module fir_mac_checks
  import fir_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input fir_mode_t        modeQ,
  input logic             resultValid,
  input logic [ACC_W-1:0] resultA,
  input logic [ACC_W-1:0] resultB
);
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resultValid && resultA == '0 && resultB == '0));

  p_one_clock_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (resultValid && (modeQ.tapsCode != '0 || modeQ.decim)) |=> !resultValid);

  p_hold_between_r10: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> ($stable(resultA) && $stable(resultB)));

  p_lane_b_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !modeQ.dual |-> (resultB == '0));

  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(modeQ));
endmodule

bind fir_mac fir_mac_checks chk (
  .clk(clk), .rst(rst), .modeQ(modeQ),
  .resultValid(resultValid), .resultA(resultA), .resultB(resultB)
);

// File: tb/fir_mac_test.sv
module fir_mac_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_D = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  modeTaps = '0;
  logic        modeDual = 1'b0, modeDecim = 1'b0;
  logic        coefWrEn = 1'b0;
  logic [6:0]  coefAddr = '0;
  logic [15:0] coefData = '0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleA = '0, sampleB = '0;
  logic [31:0] cascadeA = '0, cascadeB = '0;
  logic        resultValid;
  logic [31:0] resultA, resultB;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [15:0] coefBank [128];
  int          histA [129];
  int          histB [129];
  logic        expV [EXP_D];
  logic [31:0] expA [EXP_D];
  logic [31:0] expB [EXP_D];
  logic [15:0] stimA [256];
  logic [15:0] stimB [256];

  fir_mac uut (
    .clk(clk), .rst(rst), .modeTaps(modeTaps), .modeDual(modeDual), .modeDecim(modeDecim),
    .coefWrEn(coefWrEn), .coefAddr(coefAddr), .coefData(coefData),
    .sampleValid(sampleValid), .sampleA(sampleA), .sampleB(sampleB),
    .cascadeA(cascadeA), .cascadeB(cascadeB),
    .resultValid(resultValid), .resultA(resultA), .resultB(resultB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] nextRand();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng[30:15];
  endfunction

  function automatic int narrowed(logic [15:0] w);
    logic signed [11:0] n;
    n = w[15:4];
    return int'(n);
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply_reset(int code, bit dual, bit decim);
    @(negedge clk);
    rst = 1'b1; sampleValid = 1'b0;
    modeTaps = 2'(code); modeDual = dual; modeDecim = decim;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // kind 0: random, 1: all most-negative, 2: low nibble set
  task automatic load_coefs(int kind);
    for (int i = 0; i < 128; i++) begin
      case (kind)
        0: coefBank[i] = nextRand();
        1: coefBank[i] = 16'h8000;
        default: coefBank[i] = (i % 2 == 0) ? 16'h001F : 16'hFFFF;
      endcase
      @(negedge clk);
      coefWrEn = 1'b1; coefAddr = 7'(i); coefData = coefBank[i];
    end
    @(negedge clk);
    coefWrEn = 1'b0;
  endtask

  // skind 0: random, 1: impulse, 2: most-negative constant
  task automatic run_stream(string tag, int code, bit dual, bit decim, int skind,
                            logic [31:0] cA, logic [31:0] cB, bit scramble);
    int m, n, p, nSamp, taps, total;
    longint sA, sB;
    m = 1 << code;
    n = 16 * m;
    p = decim ? ((m / 2 < 1) ? 1 : m / 2) : m;
    taps = dual ? n / 2 : n;
    nSamp = n + 6;
    cascadeA = cA; cascadeB = cB;
    apply_reset(code, dual, decim);
    if (scramble) begin
      modeTaps = ~2'(code); modeDual = ~dual; modeDecim = ~decim; // R8
    end
    for (int i = 0; i < EXP_D; i++) begin expV[i] = 1'b0; expA[i] = '0; expB[i] = '0; end
    for (int i = 0; i < 129; i++) begin histA[i] = 0; histB[i] = 0; end
    for (int s = 0; s < nSamp; s++) begin
      case (skind)
        0: begin stimA[s] = nextRand(); stimB[s] = nextRand(); end
        1: begin stimA[s] = (s == 0) ? 16'd1000 : 16'd0; stimB[s] = (s == 0) ? 16'hFC18 : 16'd0; end
        default: begin stimA[s] = 16'h8000; stimB[s] = 16'h8000; end
      endcase
      for (int t = 128; t > 0; t--) begin histA[t] = histA[t-1]; histB[t] = histB[t-1]; end
      histA[0] = int'($signed(stimA[s]));
      histB[0] = int'($signed(stimB[s]));
      if (!decim || (s % 2 == 1)) begin
        sA = longint'(cA);
        sB = longint'(cB);
        for (int t = 0; t < taps; t++) begin
          sA += longint'(narrowed(coefBank[t])) * longint'(histA[t]);
          if (dual) sB += longint'(narrowed(coefBank[taps + t])) * longint'(histB[t]);
        end
        expV[s * p + m] = 1'b1;
        expA[s * p + m] = sA[31:0];
        expB[s * p + m] = dual ? sB[31:0] : 32'd0;
      end
    end
    total = (nSamp - 1) * p + m + 3;
    for (int c = 0; c <= total; c++) begin
      @(negedge clk);
      if (c > 0) begin
        check32({tag, "/R2"}, "resultValid", 32'(resultValid), 32'(expV[c-1]));
        if (expV[c-1]) begin
          check32(tag, "resultA", resultA, expA[c-1]);
          check32(dual ? {tag, "/R6"} : {tag, "/R6 idle"}, "resultB", resultB, expB[c-1]);
        end
      end
      if ((c % p == 0) && (c / p < nSamp)) begin
        sampleValid = 1'b1; sampleA = stimA[c / p]; sampleB = stimB[c / p];
      end else begin
        sampleValid = 1'b0; sampleA = 16'h5A5A; sampleB = 16'hA5A5;
      end
    end
    sampleValid = 1'b0;
  endtask

  task automatic test_reset_state();
    apply_reset(0, 1'b1, 1'b0);
    @(negedge clk);
    check32("R9", "resultValid after reset", 32'(resultValid), 32'd0);
    check32("R9", "resultA after reset", resultA, 32'd0);
    check32("R9", "resultB after reset", resultB, 32'd0);
  endtask

  task automatic test_single_lengths();
    load_coefs(0);
    for (int code = 0; code < 4; code++) run_stream("R1", code, 1'b0, 1'b0, 0, 32'h0000_1000, 32'h0, 1'b0);
    run_stream("R1 impulse", 2, 1'b0, 1'b0, 1, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic test_cascade();
    run_stream("R5", 1, 1'b0, 1'b0, 0, 32'h7FFF_FF00, 32'h0, 1'b0);
    run_stream("R5 dual", 0, 1'b1, 1'b0, 0, 32'h8000_0001, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic test_dual();
    for (int code = 0; code < 4; code++) run_stream("R6", code, 1'b1, 1'b0, 0, 32'h0000_0042, 32'hFFFF_FF00, 1'b0);
  endtask

  task automatic test_decimate();
    for (int code = 0; code < 4; code++) run_stream("R7", code, 1'b0, 1'b1, 0, 32'h0000_0007, 32'h0, 1'b0);
    run_stream("R7 dual", 2, 1'b1, 1'b1, 0, 32'h0, 32'h0000_0100, 1'b0);
  endtask

  task automatic test_wrap();
    load_coefs(1);
    run_stream("R4", 3, 1'b0, 1'b0, 2, 32'h7FFF_FFFF, 32'h0, 1'b0);
  endtask

  task automatic test_narrowing();
    load_coefs(2);
    run_stream("R3", 1, 1'b0, 1'b0, 0, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic test_mode_frozen();
    load_coefs(0);
    run_stream("R8", 1, 1'b0, 1'b0, 0, 32'h10, 32'h0, 1'b1);
    run_stream("R8 dual", 2, 1'b1, 1'b0, 0, 32'h0, 32'h20, 1'b1);
  endtask

  task automatic test_coef_retained();
    // R11: coefficients written before the reset inside run_stream stay in use
    run_stream("R11", 0, 1'b0, 1'b0, 0, 32'h0, 32'h0, 1'b0);
    test_reset_state();
  endtask

  initial begin
    test_reset_state();
    test_single_lengths();
    test_reset_state();
    test_cascade();
    test_dual();
    test_decimate();
    test_wrap();
    test_narrowing();
    test_mode_frozen();
    test_coef_retained();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule